// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter sits between a big-endian host bus and a block of peripheral registers whose native widths differ from one 32-bit longword of the window to the next. The host may issue 8-bit, 16-bit or 32-bit accesses at any naturally aligned offset. The adapter looks up the native width of the addressed longword in a parameter table. It then turns the host access into one or more downstream accesses of exactly that width.

A host access wider than the register is split into consecutive register-width accesses, most significant part first. A host access narrower than the register reads the whole register. For a read, it extracts the addressed lanes. For a write, it merges the new lanes into the value it read and writes the register back. Offsets outside the window, unmapped longwords and the reserved size code end with an error and never reach the register port. The downstream port returns read data in the same cycle as its request.

Top module: `regw_adapter`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `dn_req_o` are low.
- R2: The native width of an offset is the 2-bit code at bits [2n+1:2n] of `WIDTH_MAP`, where n = offset[8:2]. The codes are: 0 unmapped, 1 8-bit, 2 16-bit, 3 32-bit. By default, longword n is 8-bit when n mod 4 = 0, 16-bit when n mod 4 = 1, 32-bit when n mod 4 = 2, and unmapped when n mod 4 = 3.
- R3: An access is rejected when its offset is 0x200 or above, its longword is unmapped, or its size code is 3. A rejected access produces `done_o` and `err_o` in the cycle after acceptance, with `rdata_o` = 0. It makes no downstream access, so register contents are unchanged.
- R4: Size codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit, on both `size_i` and `dn_size_o`. Host and downstream data are right-justified. When the host size equals the register width, exactly one downstream access is made at the host offset.
- R5: When the host size is wider than the register, the adapter makes host/register accesses at ascending offsets spaced by the register width. The first access carries the most significant part of the write data. Read parts are concatenated most significant first.
- R6: When the host read is narrower than the register, one read is made at the offset with its low bits cleared to register alignment. Register bytes are big-endian, so the lowest offset maps to the most significant bits.
- R7: When the host write is narrower than the register, the adapter reads the aligned register and then writes it back in the next cycle. Only the addressed bytes are replaced.
- R8: Downstream accesses run one per cycle, starting the cycle after acceptance. `busy_o` is high while they run. `done_o` pulses for one cycle after the last one. On that pulse, `rdata_o` holds the read result, or 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Host access request, accepted when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Host access size code |
| addr_i | input | ADDR_W | Host byte offset |
| wdata_i | input | 32 | Host write data, right-justified |
| busy_o | output | 1 | Downstream sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Access rejected, valid with done |
| rdata_o | output | 32 | Read result, right-justified, valid with done |
| dn_req_o | output | 1 | Downstream register access this cycle |
| dn_we_o | output | 1 | Downstream write enable |
| dn_size_o | output | 2 | Downstream width code (native width) |
| dn_addr_o | output | ADDR_W | Downstream register offset |
| dn_wdata_o | output | 32 | Downstream write data, right-justified |
| dn_rdata_i | input | 32 | Downstream read data, same cycle as request |

## Verification
The properties assume three things about the environment:
- The host never raises a request while the adapter is busy.
- Host offsets are naturally aligned to the access size.
- The register port answers reads combinationally in the cycle of the request.

Given those, every downstream offset is aligned to its width, and a write that directly follows a read in one sequence targets the same register. The stimulus respects all three assumptions. It issues a new request only after the previous completion strobe and aligns every offset to its size, except that the reserved size code is sent unaligned because it must be rejected anyway. The register model returns data from a byte array in the same cycle as the request.

// File: rtl/regw_pkg.sv
// Shared constants, types and helpers for the mixed-width register adapter.
// Assumes a 32-bit host data path and a 0x200-byte register window.
package regw_pkg;

    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 512;
    localparam int LW_CNT    = WIN_BYTES / 4;
    localparam int MAP_W     = 2 * LW_CNT;

    // Native width code held per longword in the layout table
    typedef enum logic [1:0] {
        W_NONE = 2'd0,
        W_8    = 2'd1,
        W_16   = 2'd2,
        W_32   = 2'd3
    } wcode_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_FETCH,
        ST_STORE
    } seq_st_e;

    // Builds the default layout: widths rotate 8/16/32/unmapped per longword
    function automatic logic [MAP_W-1:0] default_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int i = 0; i < LW_CNT; i++) begin
            case (i % 4)
                0:       m[2*i +: 2] = W_8;
                1:       m[2*i +: 2] = W_16;
                2:       m[2*i +: 2] = W_32;
                default: m[2*i +: 2] = W_NONE;
            endcase
        end
        return m;
    endfunction

    // Mask covering the given number of low-order bytes
    function automatic logic [DATA_W-1:0] byte_mask(input logic [2:0] nbytes);
        if (nbytes >= 3'd4) begin
            return '1;
        end
        return (32'd1 << (8 * nbytes)) - 32'd1;
    endfunction

endpackage

// File: rtl/regw_map_lookup.sv
// Layout lookup: decodes the native register width of the addressed longword
// and flags accesses that must be rejected (outside window, unmapped, bad size).
// Assumes ADDR_W is wider than the window index plus two byte-offset bits.
module regw_map_lookup
    import regw_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [MAP_W-1:0] WIDTH_MAP = default_map()
)
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              bad_o,
    output logic [1:0]        reg_lg_o
);

    localparam int IDX_W = $clog2(LW_CNT);

    logic [IDX_W-1:0] idx;
    logic             in_win;
    wcode_e           code;

    // Table index, window test and rejection decision
    always_comb begin
        in_win   = (addr_i >> (IDX_W + 2)) == '0;
        idx      = addr_i[IDX_W+1:2];
        code     = wcode_e'(WIDTH_MAP[2*idx +: 2]);
        bad_o    = !in_win || (code == W_NONE) || (size_i == 2'd3);
        reg_lg_o = (code == W_NONE) ? 2'd0 : (code - 2'd1);
    end

endmodule

// File: rtl/regw_lanes.sv
// Byte-lane datapath: slices host write data for split accesses, extracts the
// addressed lanes from a wider register, and merges narrow write data into a
// register image. Purely combinational; big-endian lane order.
module regw_lanes
    import regw_pkg::*;
(
    input  logic [1:0]        acc_lg_i,
    input  logic [1:0]        reg_lg_i,
    input  logic [1:0]        addr_lo_i,
    input  logic [1:0]        step_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic [DATA_W-1:0] dn_rdata_i,
    output logic [DATA_W-1:0] split_wdata_o,
    output logic [DATA_W-1:0] narrow_rdata_o,
    output logic [DATA_W-1:0] merged_wdata_o,
    output logic [DATA_W-1:0] reg_part_o
);

    int                a_b;
    int                w_b;
    int                parts;
    int                lane_ofs;
    int                split_sh;
    int                lane_sh;
    logic [DATA_W-1:0] a_mask;
    logic [DATA_W-1:0] w_mask;

    // Shift amounts and lane masks from host size, register width and offset
    always_comb begin
        a_b    = 1 << acc_lg_i;
        w_b    = 1 << reg_lg_i;
        a_mask = byte_mask(3'(a_b));
        w_mask = byte_mask(3'(w_b));
        if (a_b >= w_b) begin
            parts    = a_b / w_b;
            lane_ofs = 0;
            lane_sh  = 0;
        end else begin
            parts    = 1;
            lane_ofs = int'(addr_lo_i) & (w_b - 1);
            lane_sh  = 8 * (w_b - a_b - lane_ofs);
        end
        split_sh = 8 * w_b * (parts - 1 - int'(step_i));
        if (split_sh < 0) begin
            split_sh = 0;
        end
    end

    // Data selection and merging
    always_comb begin
        split_wdata_o  = (host_wdata_i >> split_sh) & w_mask;
        narrow_rdata_o = (dn_rdata_i >> lane_sh) & a_mask;
        merged_wdata_o = (dn_rdata_i & ~(a_mask << lane_sh))
                       | ((host_wdata_i & a_mask) << lane_sh);
        reg_part_o     = dn_rdata_i & w_mask;
    end

endmodule

// File: rtl/regw_seq.sv
// Access sequencer: accepts one host access at a time and issues the
// downstream register accesses (split, fetch, store) one per cycle, then
// strobes completion. Assumes the host waits while busy and that downstream
// read data arrives in the cycle of the request.
module regw_seq
    import regw_pkg::*;
#(
    parameter int ADDR_W = 12
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              bad_i,
    input  logic [1:0]        reg_lg_i,
    input  logic [DATA_W-1:0] split_wdata_i,
    input  logic [DATA_W-1:0] narrow_rdata_i,
    input  logic [DATA_W-1:0] merged_wdata_i,
    input  logic [DATA_W-1:0] reg_part_i,
    output logic [1:0]        acc_lg_o,
    output logic [1:0]        reg_lg_o,
    output logic [1:0]        addr_lo_o,
    output logic [1:0]        step_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dn_req_o,
    output logic              dn_we_o,
    output logic [1:0]        dn_size_o,
    output logic [ADDR_W-1:0] dn_addr_o,
    output logic [DATA_W-1:0] dn_wdata_o
);

    seq_st_e           st_q;
    logic              we_q;
    logic [1:0]        acc_lg_q;
    logic [1:0]        reg_lg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        step_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] merged_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    logic [2:0]        parts_m1;
    logic [1:0]        low_clr;
    logic              split_last;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] acc_next;

    // Sequence bookkeeping derived from the latched access
    always_comb begin
        parts_m1   = 3'((3'd1 << (acc_lg_q - reg_lg_q)) - 3'd1);
        split_last = ({1'b0, step_q} == parts_m1);
        low_clr    = 2'((3'd1 << reg_lg_q) - 3'd1);
        base_addr  = addr_q & ~{{(ADDR_W-2){1'b0}}, low_clr};
        step_addr  = addr_q + (ADDR_W'(step_q) << reg_lg_q);
        acc_next   = (acc_q << (8 << reg_lg_q)) | reg_part_i;
    end

    // Downstream port drive per phase
    always_comb begin
        dn_req_o   = (st_q != ST_IDLE);
        dn_size_o  = reg_lg_q;
        dn_we_o    = 1'b0;
        dn_addr_o  = base_addr;
        dn_wdata_o = '0;
        case (st_q)
            ST_SPLIT: begin
                dn_we_o    = we_q;
                dn_addr_o  = step_addr;
                dn_wdata_o = we_q ? split_wdata_i : '0;
            end
            ST_STORE: begin
                dn_we_o    = 1'b1;
                dn_wdata_o = merged_q;
            end
            default: begin
            end
        endcase
    end

    // Phase register, latched access and completion results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            we_q     <= 1'b0;
            acc_lg_q <= '0;
            reg_lg_q <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            step_q   <= '0;
            acc_q    <= '0;
            merged_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_i) begin
                        we_q     <= we_i;
                        acc_lg_q <= size_i;
                        reg_lg_q <= reg_lg_i;
                        addr_q   <= addr_i;
                        wdata_q  <= wdata_i;
                        step_q   <= '0;
                        acc_q    <= '0;
                        if (bad_i) begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                        end else if (size_i >= reg_lg_i) begin
                            st_q <= ST_SPLIT;
                        end else begin
                            st_q <= ST_FETCH;
                        end
                    end
                end
                ST_SPLIT: begin
                    acc_q  <= acc_next;
                    step_q <= step_q + 2'd1;
                    if (split_last) begin
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                        rdata_q <= we_q ? '0 : acc_next;
                    end
                end
                ST_FETCH: begin
                    if (we_q) begin
                        merged_q <= merged_wdata_i;
                        st_q     <= ST_STORE;
                    end else begin
                        rdata_q <= narrow_rdata_i;
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                    end
                end
                default: begin
                    st_q    <= ST_IDLE;
                    done_q  <= 1'b1;
                    rdata_q <= '0;
                end
            endcase
        end
    end

    // Outputs towards the lane datapath and the host
    always_comb begin
        acc_lg_o  = acc_lg_q;
        reg_lg_o  = reg_lg_q;
        addr_lo_o = addr_q[1:0];
        step_o    = step_q;
        wdata_o   = wdata_q;
        busy_o    = (st_q != ST_IDLE);
        done_o    = done_q;
        err_o     = err_q;
        rdata_o   = rdata_q;
    end

endmodule

// File: rtl/regw_adapter.sv
// Mixed-width register access adapter top: joins the layout lookup, the
// sequencer and the byte-lane datapath. Assumes naturally aligned host
// accesses, no new request while busy, and same-cycle downstream read data.
module regw_adapter
    import regw_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [MAP_W-1:0] WIDTH_MAP = default_map()
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dn_req_o,
    output logic              dn_we_o,
    output logic [1:0]        dn_size_o,
    output logic [ADDR_W-1:0] dn_addr_o,
    output logic [DATA_W-1:0] dn_wdata_o,
    input  logic [DATA_W-1:0] dn_rdata_i
);

    logic              bad;
    logic [1:0]        reg_lg_lookup;
    logic [1:0]        acc_lg;
    logic [1:0]        reg_lg;
    logic [1:0]        addr_lo;
    logic [1:0]        step;
    logic [DATA_W-1:0] held_wdata;
    logic [DATA_W-1:0] split_wdata;
    logic [DATA_W-1:0] narrow_rdata;
    logic [DATA_W-1:0] merged_wdata;
    logic [DATA_W-1:0] reg_part;

    regw_map_lookup #(
        .ADDR_W    (ADDR_W),
        .WIDTH_MAP (WIDTH_MAP)
    ) lookup_i (
        .addr_i   (addr_i),
        .size_i   (size_i),
        .bad_o    (bad),
        .reg_lg_o (reg_lg_lookup)
    );

    regw_seq #(
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .we_i           (we_i),
        .size_i         (size_i),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .bad_i          (bad),
        .reg_lg_i       (reg_lg_lookup),
        .split_wdata_i  (split_wdata),
        .narrow_rdata_i (narrow_rdata),
        .merged_wdata_i (merged_wdata),
        .reg_part_i     (reg_part),
        .acc_lg_o       (acc_lg),
        .reg_lg_o       (reg_lg),
        .addr_lo_o      (addr_lo),
        .step_o         (step),
        .wdata_o        (held_wdata),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .rdata_o        (rdata_o),
        .dn_req_o       (dn_req_o),
        .dn_we_o        (dn_we_o),
        .dn_size_o      (dn_size_o),
        .dn_addr_o      (dn_addr_o),
        .dn_wdata_o     (dn_wdata_o)
    );

    regw_lanes lanes_i (
        .acc_lg_i       (acc_lg),
        .reg_lg_i       (reg_lg),
        .addr_lo_i      (addr_lo),
        .step_i         (step),
        .host_wdata_i   (held_wdata),
        .dn_rdata_i     (dn_rdata_i),
        .split_wdata_o  (split_wdata),
        .narrow_rdata_o (narrow_rdata),
        .merged_wdata_o (merged_wdata),
        .reg_part_o     (reg_part)
    );

endmodule

// File: rtl/regw_adapter_chk.sv
// Property checker for the mixed-width register adapter, bound to its top.
// Assumes the host respects busy and issues aligned offsets.
module regw_adapter_chk
    import regw_pkg::*;
#(
    parameter int ADDR_W = 12
)
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              dn_req_o,
    input logic              dn_we_o,
    input logic [1:0]        dn_size_o,
    input logic [ADDR_W-1:0] dn_addr_o
);

    localparam int IDX_W = $clog2(LW_CNT);

    // R3
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R3
    out_of_window_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o && ((addr_i >> (IDX_W + 2)) != '0)) |=> (done_o && err_o));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !dn_req_o);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    rmw_same_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && dn_we_o && $past(dn_req_o) && !$past(dn_we_o))
            |-> (dn_addr_o == $past(dn_addr_o)));

    // R5
    dn_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> ((dn_addr_o & ((ADDR_W'(1) << dn_size_o) - ADDR_W'(1))) == '0));

    // R2
    dn_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> ((dn_addr_o >> (IDX_W + 2)) == '0));

endmodule

bind regw_adapter regw_adapter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .addr_i    (addr_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .dn_req_o  (dn_req_o),
    .dn_we_o   (dn_we_o),
    .dn_size_o (dn_size_o),
    .dn_addr_o (dn_addr_o)
);

// File: tb/regw_adapter_tb_top.sv
`timescale 1ns/1ps
// Bench: byte-array register model on the downstream side, a behavioural
// reference that predicts every downstream cycle and each completion, and a
// per-clock comparison of the design against that prediction.
module regw_adapter_tb_top;

    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] rdata_o;
    logic        dn_req_o, dn_we_o;
    logic [1:0]  dn_size_o;
    logic [AW-1:0] dn_addr_o;
    logic [31:0] dn_wdata_o;
    logic [31:0] dn_rdata_i;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit running = 1'b0;

    logic [7:0] dev_mem [512];
    logic [7:0] ref_mem [512];

    typedef struct {
        bit          is_done;
        bit          we;
        int          addr;
        int          lg;
        logic [31:0] wd;
        bit          err;
        logic [31:0] rd;
        int          rq;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    regw_adapter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .rdata_o(rdata_o), .dn_req_o(dn_req_o), .dn_we_o(dn_we_o),
        .dn_size_o(dn_size_o), .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o),
        .dn_rdata_i(dn_rdata_i)
    );

    // Register model: same-cycle big-endian read
    always_comb begin
        dn_rdata_i = '0;
        for (int b = 0; b < 4; b++) begin
            if (b < (1 << dn_size_o)) begin
                dn_rdata_i = (dn_rdata_i << 8) | 32'(dev_mem[(int'(dn_addr_o) + b) & 511]);
            end
        end
    end

    // Register model: big-endian write at the clock edge
    always @(posedge clk) begin
        if (dn_req_o && dn_we_o) begin
            for (int b = 0; b < (1 << dn_size_o); b++) begin
                dev_mem[(int'(dn_addr_o) + b) & 511] <= dn_wdata_o[8*((1 << dn_size_o) - 1 - b) +: 8];
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Default layout from R2: n mod 4 gives 8, 16, 32 bits, unmapped
    function automatic int reg_bytes(input int off);
        case (((off >> 2) & 127) % 4)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int lg_of(input int nb);
        return (nb == 1) ? 0 : ((nb == 2) ? 1 : 2);
    endfunction

    // Per-clock comparison against the predicted cycle
    always @(negedge clk) begin
        if (running) begin
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                if (!e.is_done) begin
                    check(dn_req_o && !done_o && dn_we_o == e.we && int'(dn_addr_o) == e.addr
                          && int'(dn_size_o) == e.lg && (!e.we || dn_wdata_o == e.wd),
                          $sformatf("R%0d/R8 downstream: req=%0b done=%0b we=%0b addr=%h size=%0d wdata=%h expected req=1 done=0 we=%0b addr=%h size=%0d wdata=%h",
                                    e.rq, dn_req_o, done_o, dn_we_o, dn_addr_o, dn_size_o, dn_wdata_o,
                                    e.we, e.addr, e.lg, e.wd));
                end else begin
                    check(done_o && !dn_req_o && !busy_o && err_o == e.err && rdata_o == e.rd,
                          $sformatf("R%0d/R8 completion: done=%0b req=%0b busy=%0b err=%0b rdata=%h expected done=1 req=0 busy=0 err=%0b rdata=%h",
                                    e.rq, done_o, dn_req_o, busy_o, err_o, rdata_o, e.err, e.rd));
                end
            end else begin
                check(!dn_req_o && !done_o,
                      $sformatf("R8 idle: req=%0b done=%0b expected req=0 done=0", dn_req_o, done_o));
            end
        end
    end

    // One host access with predicted downstream cycles and completion
    task automatic access(input bit we, input int size, input int addr, input logic [31:0] wd);
        int ab, wb, base, rq;
        bit rej;
        logic [31:0] rd;
        logic [7:0] after [512];
        exp_t e;
        @(negedge clk);
        req_i = 1'b1; we_i = we; size_i = 2'(size); addr_i = AW'(addr); wdata_i = wd;
        @(posedge clk);
        #1;
        req_i = 1'b0;
        rej = (addr >= 512) || (size == 3) || (reg_bytes(addr) == 0);
        rd = '0;
        rq = 3;
        if (!rej) begin
            ab = 1 << size;
            wb = reg_bytes(addr);
            after = ref_mem;
            if (we) begin
                for (int b = 0; b < ab; b++) after[addr + b] = wd[8*(ab - 1 - b) +: 8];
            end else begin
                for (int b = 0; b < ab; b++) rd = (rd << 8) | 32'(ref_mem[addr + b]);
            end
            rq = (ab == wb) ? 4 : ((ab > wb) ? 5 : (we ? 7 : 6));
            if (ab >= wb) begin
                for (int k = 0; k < ab / wb; k++) begin
                    e = '{is_done:1'b0, we:we, addr:addr + k*wb, lg:lg_of(wb), wd:'0, err:1'b0, rd:'0, rq:rq};
                    for (int b = 0; b < wb; b++) e.wd = (e.wd << 8) | 32'(after[addr + k*wb + b]);
                    expq.push_back(e);
                end
            end else begin
                base = addr & ~(wb - 1);
                e = '{is_done:1'b0, we:1'b0, addr:base, lg:lg_of(wb), wd:'0, err:1'b0, rd:'0, rq:rq};
                expq.push_back(e);
                if (we) begin
                    e.we = 1'b1;
                    for (int b = 0; b < wb; b++) e.wd = (e.wd << 8) | 32'(after[base + b]);
                    expq.push_back(e);
                end
            end
            ref_mem = after;
        end
        e = '{is_done:1'b1, we:1'b0, addr:0, lg:0, wd:'0, err:rej, rd:(rej || we) ? 32'd0 : rd, rq:rq};
        expq.push_back(e);
        for (int t = 0; t < 20 && expq.size() != 0; t++) @(posedge clk);
        if (expq.size() != 0) begin
            check(1'b0, $sformatf("R8 sequence stalled: %0d cycles left expected 0", expq.size()));
            expq.delete();
        end
        begin
            int diff;
            diff = 0;
            for (int i = 0; i < 512; i++) if (dev_mem[i] !== ref_mem[i]) diff++;
            check(diff == 0, $sformatf("R%0d register contents after access at %h: %0d bytes differ expected 0",
                                       rq, addr, diff));
        end
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            dev_mem[i] = 8'(i * 37 + 11);
            ref_mem[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !err_o && !dn_req_o,
              $sformatf("R1 reset: busy=%0b done=%0b err=%0b req=%0b expected all 0",
                        busy_o, done_o, err_o, dn_req_o));
        running = 1'b1;

        // R4: matched widths
        access(0, 0, 'h001, 32'h0);
        access(1, 0, 'h002, 32'h000000A5);
        access(1, 1, 'h006, 32'h0000BEEF);
        access(0, 1, 'h006, 32'h0);
        access(1, 2, 'h008, 32'h12345678);
        access(0, 2, 'h008, 32'h0);
        // R6: narrow reads of wider registers
        access(0, 0, 'h004, 32'h0);
        access(0, 0, 'h005, 32'h0);
        access(0, 0, 'h008, 32'h0);
        access(0, 1, 'h00A, 32'h0);
        // R7: narrow writes, read-modify-write
        access(1, 0, 'h005, 32'hFFFFFF3C);
        access(1, 0, 'h104, 32'h0000007E);
        access(1, 1, 'h008, 32'hCAFED00D);
        access(1, 1, 'h10A, 32'h00004321);
        access(1, 0, 'h00B, 32'h00000099);
        access(0, 2, 'h008, 32'h0);
        // R5: wide accesses split across narrower registers
        access(1, 1, 'h000, 32'h0000A1B2);
        access(0, 1, 'h000, 32'h0);
        access(1, 2, 'h010, 32'hDEADBEEF);
        access(0, 2, 'h010, 32'h0);
        access(1, 2, 'h004, 32'h01234567);
        access(0, 2, 'h004, 32'h0);
        // R3: rejected accesses leave registers untouched
        access(0, 0, 'h00C, 32'h0);
        access(1, 2, 'h00C, 32'hFFFFFFFF);
        access(1, 1, 'h200, 32'h00005555);
        access(0, 2, 'hFFC, 32'h0);
        access(1, 3, 'h008, 32'h77777777);
        access(1, 2, 'h1FC, 32'h11111111);
        // R2: layout at the top of the window
        access(1, 2, 'h1F0, 32'h89ABCDEF);
        access(0, 1, 'h1F4, 32'h0);
        access(1, 0, 'h1F9, 32'h0000005A);
        access(0, 2, 'h1F8, 32'h0);
        // Mixed sequence over all sizes and offsets
        for (int n = 0; n < 300; n++) begin
            int sz, ad;
            sz = int'($urandom_range(0, 3));
            ad = int'($urandom_range(0, 639));
            if (sz < 3) ad = ad & ~((1 << sz) - 1);
            access(1'($urandom_range(0, 1)), sz, ad, $urandom);
        end
        running = 1'b0;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule